// File: doc/BRIEF.md
# Dual-Mode Receive Payload Serial Output

This block sits at the system-side edge of a receive framer. On every rising edge of the line clock it takes in one recovered bit, together with a tag from the framer that marks the bit as payload or overhead. It then presents that bit on a serial data output for one full line-clock period. Payload and overhead bits both appear on that output, whatever the mode.

A single companion output pin has two roles, and a mode input picks the role. In serial mode the pin is an overhead flag. The downstream equipment samples it on the falling line-clock edge and keeps the data bit only when the flag is low. In gapped-clock mode the pin is a payload clock instead. It gives one glitch-free pulse in each payload bit period and stays low in each overhead bit period. Each pulse rises at the falling line-clock edge, in the middle of the bit, so the downstream equipment can clock the data in on that edge and needs no gating logic of its own.

Top module: `payload_ser_out`

## Requirements
- R1: `dout` equals the value of `din` sampled at the previous rising edge of `clk`, in both modes, whether that bit is payload or overhead.
- R2: In serial mode (`mode_gap`=0 at the capturing edge), `ind_out` is 1 for the whole bit period of a bit whose `oh_tag` was 1.
- R3: In serial mode, `ind_out` is 0 for the whole bit period of a bit whose `oh_tag` was 0 (payload).
- R4: In gapped-clock mode (`mode_gap`=1 at the capturing edge), a payload bit period (`oh_tag`=0) holds exactly one pulse on `ind_out`. The pulse is 0 while `clk` is high and 1 while `clk` is low, so it rises at the falling edge of `clk`.
- R5: In gapped-clock mode, `ind_out` stays 0 for the whole period of an overhead bit (`oh_tag`=1), so no pulse appears.
- R6: `mode_gap` is captured at the rising edge of `clk` together with the bit. A change of mode applies from the bit captured at that same edge, and earlier bits keep their old meaning.
- R7: While `rst_n` is 0 at a rising edge of `clk`, the next bit period has `dout`=0 and `ind_out`=0, and the block is in serial mode.
- R8: For the same input stream, the payload bits taken in serial mode (on the falling edge, when the flag is low) and in gapped-clock mode (on each pulse's rising edge) form the same sequence. That sequence equals the stream's payload bits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Line clock. One bit per period. |
| rst_n | input | 1 | Synchronous reset, active low. |
| mode_gap | input | 1 | 0 selects serial mode (overhead flag); 1 selects gapped-clock mode. |
| din | input | 1 | Recovered serial bit from the framer. |
| oh_tag | input | 1 | 1 when `din` is an overhead bit, 0 when it is payload. |
| dout | output | 1 | Serial data output. Carries every bit for one line-clock period. |
| ind_out | output | 1 | Overhead flag in serial mode; gapped payload clock in gapped-clock mode. |

## Verification
The bench checks `ind_out` in both halves of every bit period. A gate that let the clock's high phase through, or that enabled the pulse one bit late, would give pulses on overhead bits or pulses shifted by one bit. It runs the same tagged stream through both modes and compares the payload taken in each with the expected list. An off-by-one register on the flag, or a pulse on an overhead bit, would make the two lists differ. It also switches mode in the middle of a stream, and it runs windows of all overhead and all payload. A mode applied one bit late, or a clock that keeps running through overhead, would be caught there. Reset asserted in the middle of a stream with `din`=1 and `oh_tag`=1 checks that the outputs are forced low.

// File: rtl/pso_pkg.sv
// Package: shared definitions for the dual-mode payload serial output.
// Assumes: nothing. It only holds the encoding of the indicator pin's role.
package pso_pkg;
    typedef enum logic {
        IND_FLAG  = 1'b0,   // indicator pin carries the overhead flag
        IND_GCLK  = 1'b1    // indicator pin carries the gapped payload clock
    } ind_role_e;
endpackage

// File: rtl/pso_bit_reg.sv
// Module: bit-period register stage.
// Captures the incoming bit, its overhead tag and the requested role of the
// indicator pin on the rising edge of the line clock. Each captured value then
// holds for one full bit period.
// Assumes: inputs are synchronous to clk; reset is synchronous, active low.
module pso_bit_reg
    import pso_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      bit_in,
    input  logic      ovh_in,
    input  logic      role_in,
    output logic      bit_q,
    output logic      ovh_q,
    output ind_role_e role_q
);
    // Purpose: hold bit, tag and mode for the bit period; clear all of them on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bit_q  <= 1'b0;
            ovh_q  <= 1'b0;
            role_q <= IND_FLAG;
        end else begin
            bit_q  <= bit_in;
            ovh_q  <= ovh_in;
            role_q <= ind_role_e'(role_in);
        end
    end
endmodule

// File: rtl/pso_gap_clk.sv
// Module: glitch-free gapped clock former.
// The enable is taken through a latch that is open while clk is high and
// closed while clk is low. The pulse is the held enable ANDed with the low
// phase of clk. It therefore covers a whole low phase and rises at the
// falling edge of clk, in the middle of the bit.
// Assumes: pay_en changes only just after the rising edge of clk.
module pso_gap_clk (
    input  logic clk,
    input  logic pay_en,
    output logic gclk
);
    logic en_hold;

    // Purpose: track the enable during the high phase and freeze it for the low phase.
    always_latch begin
        if (clk) begin
            en_hold = pay_en;
        end
    end

    // Purpose: let the low phase through only when the frozen enable is set.
    always_comb begin
        gclk = en_hold & ~clk;
    end
endmodule

// File: rtl/pso_ind_sel.sv
// Module: indicator pin role selector.
// Drives the pin with the registered overhead flag or with the gapped clock,
// following the role registered for the current bit.
// Assumes: role only changes at a rising edge of clk, while gclk is low.
module pso_ind_sel
    import pso_pkg::*;
(
    input  ind_role_e role,
    input  logic      ovh_flag,
    input  logic      gclk,
    output logic      ind
);
    // Purpose: choose the meaning of the indicator pin for this bit period.
    always_comb begin
        unique case (role)
            IND_GCLK: ind = gclk;
            default:  ind = ovh_flag;
        endcase
    end
endmodule

// File: rtl/payload_ser_out.sv
// Module: dual-mode receive payload serial output (top).
// Presents every recovered bit on dout for one line-clock period. ind_out is
// an overhead flag in serial mode or a gapped payload clock in gapped mode.
// Assumes: din, oh_tag and mode_gap are synchronous to clk; rst_n is
// synchronous and active low.
module payload_ser_out
    import pso_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic mode_gap,
    input  logic din,
    input  logic oh_tag,
    output logic dout,
    output logic ind_out
);
    logic      bit_q;
    logic      ovh_q;
    ind_role_e role_q;
    logic      mode_gap_q;
    logic      pay_en;
    logic      gclk;

    pso_bit_reg u_reg (
        .clk     (clk),
        .rst_n   (rst_n),
        .bit_in  (din),
        .ovh_in  (oh_tag),
        .role_in (mode_gap),
        .bit_q   (bit_q),
        .ovh_q   (ovh_q),
        .role_q  (role_q)
    );

    // Purpose: enable a pulse only for payload bits in gapped mode.
    always_comb begin
        mode_gap_q = (role_q == IND_GCLK);
        pay_en     = mode_gap_q & ~ovh_q;
    end

    pso_gap_clk u_gclk (
        .clk    (clk),
        .pay_en (pay_en),
        .gclk   (gclk)
    );

    pso_ind_sel u_sel (
        .role     (role_q),
        .ovh_flag (ovh_q),
        .gclk     (gclk),
        .ind      (ind_out)
    );

    // Purpose: drive the serial data pin from the bit register.
    always_comb begin
        dout = bit_q;
    end
endmodule

// File: rtl/pso_chk.sv
// Module: assertion checker for payload_ser_out, attached with bind.
// Assumes: mode_gap_q is the top's registered mode (1 = gapped clock).
module pso_chk (
    input logic clk,
    input logic rst_n,
    input logic mode_gap,
    input logic din,
    input logic oh_tag,
    input logic dout,
    input logic ind_out,
    input logic mode_gap_q
);
    AST_DATA_DELAY: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> (dout == $past(din)));                                  // R1
    AST_SER_OVH_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode_gap && oh_tag) |=> ind_out);                               // R2
    AST_SER_PAY_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode_gap && !oh_tag) |=> !ind_out);                             // R3
    AST_GAP_PULSE_LOW_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_gap && !oh_tag) |=> ind_out);                               // R4
    AST_GAP_NO_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_gap && oh_tag) |=> !ind_out);                               // R5
    AST_GAP_HIGH_PHASE_QUIET: assert property (@(negedge clk) disable iff (!rst_n)
        mode_gap_q |-> !ind_out);                                         // R4
endmodule

bind payload_ser_out pso_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .mode_gap   (mode_gap),
    .din        (din),
    .oh_tag     (oh_tag),
    .dout       (dout),
    .ind_out    (ind_out),
    .mode_gap_q (mode_gap_q)
);

// File: tb/payload_ser_out_tb.sv
// Bench: behavioural reference model compared in both halves of every bit,
// plus payload recovery in both modes.
module payload_ser_out_tb;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic mode_gap = 1'b0;
    logic din = 1'b0;
    logic oh_tag = 1'b0;
    wire  dout;
    wire  ind_out;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    payload_ser_out u_dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .mode_gap (mode_gap),
        .din      (din),
        .oh_tag   (oh_tag),
        .dout     (dout),
        .ind_out  (ind_out)
    );

    always #10 clk = ~clk;   // 50 MHz

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Reference model: what the current bit period should carry.
    logic m_d = 1'b0, m_t = 1'b0, m_g = 1'b0, m_rst = 1'b1, m_chg = 1'b0;
    always @(posedge clk) begin
        m_rst <= !rst_n;
        if (!rst_n) begin
            m_d <= 1'b0; m_t <= 1'b0; m_g <= 1'b0; m_chg <= 1'b0;
        end else begin
            m_chg <= (mode_gap != m_g);
            m_d <= din; m_t <= oh_tag; m_g <= mode_gap;
        end
    end

    // Per-cycle compare in the high phase and in the low phase.
    always @(posedge clk) begin
        #3;
        check(dout === m_d, m_rst ? "R7" : "R1", "dout high phase", dout, m_d);
        if (m_rst)
            check(ind_out === 1'b0, "R7", "ind after reset", ind_out, 0);
        else if (m_g)
            check(ind_out === 1'b0, m_chg ? "R6" : (m_t ? "R5" : "R4"),
                  "gapped ind high phase", ind_out, 0);
        else
            check(ind_out === m_t, m_chg ? "R6" : (m_t ? "R2" : "R3"),
                  "serial ind high phase", ind_out, m_t);
        @(negedge clk);
        #3;
        check(dout === m_d, "R1", "dout low phase", dout, m_d);
        if (m_rst)
            check(ind_out === 1'b0, "R7", "ind low phase after reset", ind_out, 0);
        else if (m_g)
            check(ind_out === !m_t, m_chg ? "R6" : (m_t ? "R5" : "R4"),
                  "gapped ind low phase", ind_out, !m_t);
        else
            check(ind_out === m_t, m_chg ? "R6" : (m_t ? "R2" : "R3"),
                  "serial ind low phase", ind_out, m_t);
    end

    // Payload capture as downstream equipment would do it.
    bit exp_q[$];
    bit ser_q[$];
    bit gap_q[$];
    bit cap_ser = 1'b0;
    bit cap_gap = 1'b0;
    int pulses = 0;

    always @(negedge clk) if (cap_ser && !ind_out) ser_q.push_back(dout);
    always @(posedge ind_out) begin
        pulses++;
        if (cap_gap) gap_q.push_back(dout);
    end

    function automatic bit pat_bit(input int i);
        return bit'((((i * 37) >> 2) ^ (i / 5)) & 1);
    endfunction
    function automatic bit pat_oh(input int i);
        return ((i % 12) < 2) || ((i % 12) == 7);
    endfunction

    task automatic drive(input bit d, input bit t, input bit g);
        @(posedge clk); #5;
        din = d; oh_tag = t; mode_gap = g;
    endtask

    // Fresh start: reset, then idle overhead bits in the chosen mode.
    task automatic restart(input bit g);
        @(posedge clk); #5;
        rst_n = 1'b0; din = 1'b1; oh_tag = 1'b1; mode_gap = g;
        @(posedge clk); @(posedge clk); #5;
        rst_n = 1'b1;
        drive(1'b0, 1'b1, g);
        drive(1'b0, 1'b1, g);
    endtask

    task automatic run_stream(input bit g, input int n);
        exp_q.delete();
        if (g) cap_gap = 1'b1; else cap_ser = 1'b1;
        for (int i = 0; i < n; i++) begin
            drive(pat_bit(i), pat_oh(i), g);
            if (!pat_oh(i)) exp_q.push_back(pat_bit(i));
        end
        for (int i = 0; i < 3; i++) drive(1'b0, 1'b1, g);
        cap_ser = 1'b0; cap_gap = 1'b0;
    endtask

    initial begin
        int p0;
        // Reset state.
        @(posedge clk); @(posedge clk); #3;
        check(dout === 1'b0, "R7", "dout in reset", dout, 0);
        check(ind_out === 1'b0, "R7", "ind in reset", ind_out, 0);

        // Serial mode payload recovery.
        restart(1'b0);
        run_stream(1'b0, 96);
        check(ser_q.size() == exp_q.size(), "R8", "serial payload count",
              ser_q.size(), exp_q.size());
        for (int i = 0; i < exp_q.size() && i < ser_q.size(); i++)
            check(ser_q[i] == exp_q[i], "R8", "serial payload bit", ser_q[i], exp_q[i]);

        // Gapped-clock mode with the same stream.
        restart(1'b1);
        run_stream(1'b1, 96);
        check(gap_q.size() == exp_q.size(), "R8", "gapped payload count",
              gap_q.size(), exp_q.size());
        for (int i = 0; i < exp_q.size() && i < gap_q.size(); i++)
            check(gap_q[i] == exp_q[i], "R8", "gapped payload bit", gap_q[i], exp_q[i]);
        check(gap_q.size() == ser_q.size(), "R8", "modes agree on count",
              gap_q.size(), ser_q.size());

        // All-overhead window in gapped mode: no pulses.
        p0 = pulses;
        for (int i = 0; i < 20; i++) drive(1'b1, 1'b1, 1'b1);
        drive(1'b1, 1'b1, 1'b1);
        check(pulses == p0, "R5", "pulses over overhead window", pulses - p0, 0);

        // All-payload window: one pulse per bit.
        p0 = pulses;
        for (int i = 0; i < 20; i++) drive(i[0], 1'b0, 1'b1);
        drive(1'b0, 1'b1, 1'b1);
        @(posedge clk); #3;
        check(pulses - p0 == 20, "R4", "pulses over payload window", pulses - p0, 20);

        // Mode switching mid-stream (the per-cycle model covers the checks).
        for (int i = 0; i < 40; i++) drive(pat_bit(i), pat_oh(i), (i / 5) % 2 == 1);

        // Reset in mid-stream with din and tag high.
        drive(1'b1, 1'b1, 1'b0);
        #0 rst_n = 1'b0;
        @(posedge clk); #3;
        check(dout === 1'b0, "R7", "dout after mid reset", dout, 0);
        check(ind_out === 1'b0, "R7", "ind after mid reset", ind_out, 0);
        @(posedge clk); #5 rst_n = 1'b1;
        for (int i = 0; i < 10; i++) drive(pat_bit(i), pat_oh(i), 1'b0);
        @(posedge clk); @(posedge clk); #8;

        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(20 * 100000);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog run did not end actual=1 expected=0");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule